// File: doc/BRIEF.md
# Display Port and Run-Control Register Block

This block sits on a 16-bit processor memory bus and answers three fixed addresses. A status word tells software when the character display can take another byte, a write-only data word hands one byte to an outgoing character stream, and a control word holds the run latch that enables the processor clock. Software first polls the status word until its ready flag is set. It then writes the byte to the data word. To halt the machine, it writes the control word with bit 15 cleared.

The byte stream uses a valid/ready handshake. After a write, the ready flag stays low until the sink takes the byte. If a write reaches the data word while the flag is low, the write is dropped and a sticky overrun flag is raised. The run latch comes out of reset set. It can be set again only by the external start input or by reset. Writing a 1 to it does nothing.

Top module: `disp_run_regs`

## Requirements
- R1: After a synchronous reset, `ch_valid` is 0, `run` is 1, `bus_rdata` is 0, and the status word reads 0x8000.
- R2: A read of address 0xFE04 returns the status word on `bus_rdata` in the cycle after the request. Bit 15 is ready and bit 14 is overrun, both taken from before the read edge. All other bits are 0.
- R3: A write to 0xFE06 while ready is 1 places `bus_wdata[7:0]` on `ch_data` and raises `ch_valid` in the next cycle. It also clears ready.
- R4: `ch_valid` and `ch_data` hold steady while `ch_ready` is low. After the cycle in which both are high, `ch_valid` is 0 and ready is 1 again.
- R5: A write to 0xFE06 while ready is 0 is dropped, leaving `ch_data` unchanged. It sets overrun (status bit 14), which stays set until reset, even after later accepted bytes.
- R6: A read of 0xFFFE returns the run latch in bit 15, with all other bits 0.
- R7: A write to 0xFFFE with bit 15 equal to 0 drives `run` low in the next cycle. A write with bit 15 equal to 1 leaves `run` unchanged.
- R8: `start` high sets `run` in the next cycle. If `start` arrives in the same cycle as a clearing write to 0xFFFE, the clearing write wins.
- R9: Reads of 0xFE06 and of any unmapped address return 0. Writes to 0xFE04 or to unmapped addresses change neither the stream nor the run latch nor the status word.
- R10: A write to 0xFE06 in the same cycle as a stream handshake is judged against the ready flag from before that edge. It is therefore dropped and sets overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | External request to set the run latch |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, valid the cycle after a read |
| ch_data | output | 8 | Outgoing character |
| ch_valid | output | 1 | Character valid |
| ch_ready | input | 1 | Sink accepts the character |
| run | output | 1 | Run latch, processor clock enable |

## Verification
Two pairs of events can meet in the same cycle. The first is a stream handshake and a new write to the data word. The bench raises `ch_ready` in the same cycle as the write. It expects the write to be dropped, `ch_valid` to fall, the old byte to stay on `ch_data`, and the status word to read 0xC000. The second is the `start` pulse and a clearing control write. Both are driven in one cycle, and the bench expects `run` to end low. Around these two cases, the bench sweeps all 256 byte values with varied sink stalls, 64 control-word values, and 512 addresses of the top page, and computes each expected word from the address and flag state.

// File: rtl/disp_run_pkg.sv
package disp_run_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/disp_addr_dec.sv
module disp_addr_dec
  import disp_run_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFFFE
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == STAT_ADDR)      sel = SEL_STAT;
    else if (addr == DATA_ADDR) sel = SEL_DATA;
    else if (addr == CTRL_ADDR) sel = SEL_CTRL;
    else                        sel = SEL_NONE;
  end
endmodule

// File: rtl/disp_port.sv
module disp_port #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_char,
  output logic [CHAR_W-1:0] ch_data,
  output logic              ch_valid,
  input  logic              ch_ready,
  output logic              ready,
  output logic              overrun
);
  logic take;
  logic drop;

  assign take  = wr_en && !ch_valid;
  assign drop  = wr_en && ch_valid;
  assign ready = !ch_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_valid <= 1'b0;
      ch_data  <= '0;
      overrun  <= 1'b0;
    end else begin
      if (take) begin
        ch_valid <= 1'b1;
        ch_data  <= wr_char;
      end else if (ch_valid && ch_ready) begin
        ch_valid <= 1'b0;
      end
      if (drop) overrun <= 1'b1;
    end
  end

  assert_stream_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (ch_valid && !ch_ready) |=> (ch_valid && $stable(ch_data)));

  assert_accept_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ch_valid) |=> (ch_valid && ch_data == $past(wr_char)));

  assert_drop_sets_overrun_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ch_valid) |=> (overrun && ch_data == $past(ch_data)));

  assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

// File: rtl/run_latch.sv
module run_latch (
  input  logic clk,
  input  logic rst,
  input  logic clr_wr,
  input  logic start,
  output logic run
);
  always_ff @(posedge clk) begin
    if (rst)         run <= 1'b1;
    else if (clr_wr) run <= 1'b0;
    else if (start)  run <= 1'b1;
  end

  assert_stop_only_by_write_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |-> $past(clr_wr));

  assert_restart_only_by_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> ($past(start) || $past(rst)));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && start) |=> !run);
endmodule

// File: rtl/disp_run_regs.sv
module disp_run_regs
  import disp_run_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CHAR_W-1:0] ch_data,
  output logic              ch_valid,
  input  logic              ch_ready,
  output logic              run
);
  localparam int unsigned TOP = DATA_W - 1;

  reg_sel_e sel;
  logic     rd_req;
  logic     wr_req;
  logic     ready;
  logic     overrun;
  logic     unused_wdata_bits;

  assign rd_req = bus_sel && !bus_we;
  assign wr_req = bus_sel && bus_we;
  assign unused_wdata_bits = ^bus_wdata[TOP-1:CHAR_W];

  disp_addr_dec #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
    .DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  disp_port #(.CHAR_W(CHAR_W)) u_port (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_req && sel == SEL_DATA),
    .wr_char (bus_wdata[CHAR_W-1:0]),
    .ch_data (ch_data),
    .ch_valid(ch_valid),
    .ch_ready(ch_ready),
    .ready   (ready),
    .overrun (overrun)
  );

  run_latch u_run (
    .clk   (clk),
    .rst   (rst),
    .clr_wr(wr_req && sel == SEL_CTRL && !bus_wdata[TOP]),
    .start (start),
    .run   (run)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_req) begin
      case (sel)
        SEL_STAT: bus_rdata <= {ready, overrun, {(DATA_W-2){1'b0}}};
        SEL_CTRL: bus_rdata <= {run, {(DATA_W-1){1'b0}}};
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assert_unmapped_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_req && (sel == SEL_NONE || sel == SEL_DATA)) |=> (bus_rdata == '0));

  assert_status_ready_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_req && sel == SEL_STAT) |=> (bus_rdata[TOP] == $past(!ch_valid)));

  assert_ctrl_read_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_req && sel == SEL_CTRL) |=> (bus_rdata[TOP-1:0] == '0));

  assert_handshake_write_dropped_R10: assert property (@(posedge clk) disable iff (rst)
    (ch_valid && ch_ready && wr_req && sel == SEL_DATA) |=> (!ch_valid && overrun));
endmodule

// File: tb/test_disp_run_regs.sv
module test_disp_run_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_STAT = 16'hFE04;
  localparam logic [15:0] A_DATA = 16'hFE06;
  localparam logic [15:0] A_CTRL = 16'hFFFE;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  ch_data;
  logic        ch_valid;
  logic        ch_ready = 1'b0;
  logic        run;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_run_regs i_disp_run_regs (
    .clk(clk), .rst(rst), .start(start),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_data(ch_data), .ch_valid(ch_valid), .ch_ready(ch_ready), .run(run)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] v);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    v = bus_rdata;
  endtask

  task automatic handshake();
    ch_ready = 1'b1;
    @(negedge clk);
    ch_ready = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] d;
    logic [15:0] exp;
    logic        exp_run;

    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 valid", {15'b0, ch_valid}, 16'h0000);
    check("R1 run", {15'b0, run}, 16'h0001);
    check("R1 rdata", bus_rdata, 16'h0000);
    rd(A_STAT, v);
    check("R1/R2 status", v, 16'h8000);

    // R3/R4 sweep every byte with varied sink stalls
    for (int b = 0; b < 256; b++) begin
      wr(A_DATA, {8'(b * 37 + 5), 8'(b)});
      check("R3 valid", {15'b0, ch_valid}, 16'h0001);
      check("R3 data", {8'h00, ch_data}, {8'h00, 8'(b)});
      rd(A_STAT, v);
      check("R2/R3 busy status", v, 16'h0000);
      for (int s = 0; s < b % 3; s++) begin
        @(negedge clk);
        check("R4 hold", {7'b0, ch_valid, ch_data}, {7'b0, 1'b1, 8'(b)});
      end
      handshake();
      check("R4 released", {15'b0, ch_valid}, 16'h0000);
      rd(A_STAT, v);
      check("R4 ready again", v, 16'h8000);
    end

    // R10 write during the handshake cycle
    do_reset();
    wr(A_DATA, 16'h0010);
    ch_ready = 1'b1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_DATA; bus_wdata = 16'h0020;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; ch_ready = 1'b0;
    check("R10 valid", {15'b0, ch_valid}, 16'h0000);
    check("R10 data kept", {8'h00, ch_data}, 16'h0010);
    rd(A_STAT, v);
    check("R10 status", v, 16'hC000);

    // R5 overrun
    do_reset();
    wr(A_DATA, 16'h0041);
    wr(A_DATA, 16'h0042);
    check("R5 data kept", {7'b0, ch_valid, ch_data}, {7'b0, 1'b1, 8'h41});
    rd(A_STAT, v);
    check("R5 status busy+ovr", v, 16'h4000);
    handshake();
    check("R5 no second byte", {15'b0, ch_valid}, 16'h0000);
    rd(A_STAT, v);
    check("R5 status ready+ovr", v, 16'hC000);
    wr(A_DATA, 16'h0043);
    check("R5 later accept", {8'h00, ch_data}, 16'h0043);
    rd(A_STAT, v);
    check("R5 sticky", v, 16'h4000);
    handshake();
    do_reset();
    rd(A_STAT, v);
    check("R5/R1 cleared by reset", v, 16'h8000);

    // R6/R7/R8 control word sweep
    exp_run = 1'b1;
    for (int i = 0; i < 64; i++) begin
      d = 16'(i * 1031);
      d[15] = i[0];
      wr(A_CTRL, d);
      if (!d[15]) exp_run = 1'b0;
      check("R7 run after write", {15'b0, run}, {15'b0, exp_run});
      rd(A_CTRL, v);
      check("R6 ctrl read", v, {exp_run, 15'b0});
      if (!exp_run) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        exp_run = 1'b1;
        check("R8 start", {15'b0, run}, 16'h0001);
      end
    end
    start = 1'b1;
    wr(A_CTRL, 16'h0000);
    start = 1'b0;
    check("R8 clear wins", {15'b0, run}, 16'h0000);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 restart", {15'b0, run}, 16'h0001);

    // R9 address sweep of the top page with ready=1, overrun=1, run=1
    do_reset();
    wr(A_DATA, 16'h0041);
    wr(A_DATA, 16'h0042);
    handshake();
    for (int a = 0; a < 512; a++) begin
      logic [15:0] ad;
      ad = 16'hFE00 + 16'(a);
      rd(ad, v);
      exp = (ad == A_STAT) ? 16'hC000 : (ad == A_CTRL) ? 16'h8000 : 16'h0000;
      check("R9/R2/R6 read sweep", v, exp);
    end
    for (int a = 0; a < 512; a++) begin
      logic [15:0] ad;
      ad = 16'hFE00 + 16'(a);
      if (ad != A_DATA && ad != A_CTRL) begin
        wr(ad, 16'h0000);
        check("R9 write ignored", {14'b0, run, ch_valid}, 16'h0002);
      end
    end
    rd(A_STAT, v);
    check("R9 status unchanged", v, 16'hC000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule